// File: doc/BRIEF.md
# Memoizing Compute Station

The compute station sits in front of a core's arithmetic unit. It takes one dispatched operation at a time: a 2-bit opcode and two operands. Before any arithmetic starts, the station compares the full operation (opcode together with both operands) against a small table of recently computed results. If the same operation is already in the table, the stored answer comes back on the next cycle and the arithmetic unit is never used.

On a miss the station latches the operation, starts the arithmetic unit, and counts down a latency that is fixed per opcode. It takes the unit's output only when that countdown runs out, so a slow operation has settled before its result is captured. The result is then returned and written into the table. When the table is full, the entry to evict is chosen by a build-time policy: first-in-first-out, or least-recently-used. Two 32-bit counters report how many operations were looked up and how many of those hit.

Top module: `compute_station`

## Requirements
- R1: After reset `disp_ready` is 1, `res_valid` is 0 and both counters are 0. `disp_ready` stays 0 from the edge that accepts a missing operation until the cycle its result appears.
- R2: A miss returns the opcode applied to the operands, taken to 32 bits. Opcode 0 is A+B, 1 is A−B, 2 is the low half of A×B, and 3 is the signed maximum of A and B.
- R3: A miss result appears with `res_hit`=0, LAT+1 cycles after the accepting edge. LAT is 1 for opcodes 0 and 1, 4 for opcode 2 and 2 for opcode 3 (the defaults). `res_valid` lasts one cycle unless another operation is accepted.
- R4: An operation whose opcode and operands equal a stored entry returns the stored value with `res_hit`=1 one cycle after the accepting edge, and `disp_ready` stays 1.
- R5: An operation that differs from every stored entry in the opcode or in either operand is a miss, even if its arithmetic value equals a stored one.
- R6: `lookup_count` rises by 1 on every accepted operation, and `hit_count` rises by 1 on every accepted operation that hits.
- R7: Reset empties the table. Empty entries are filled before any entry is evicted, so after DEPTH distinct misses all DEPTH operations hit.
- R8: With the FIFO policy a full table evicts the entry written earliest, and hits do not change that order.
- R9: With the LRU policy a full table evicts the entry whose last write or hit is oldest.
- R10: An operation presented while `disp_ready` is 0 is ignored. It is not counted, not computed and not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Operation presented |
| disp_ready | output | 1 | Station idle, operation will be accepted |
| disp_op | input | 2 | Opcode (0 add, 1 sub, 2 mul, 3 signed max) |
| disp_a | input | DW (32) | Operand A |
| disp_b | input | DW (32) | Operand B |
| res_valid | output | 1 | Result present this cycle |
| res_value | output | DW (32) | Result value |
| res_hit | output | 1 | Result came from the table |
| lookup_count | output | 32 | Accepted operations |
| hit_count | output | 32 | Accepted operations that hit |

## Verification
Some properties are checked by assertions on every cycle. An accepted operation must be followed either by a hit result or by a dropped ready. A miss result may only follow a cycle in which the station was busy. A hit result must follow an acceptance by exactly one cycle. The counters must step exactly with acceptances and hits, and they must hold while nothing is accepted. Other behaviour can only be shown by the bench's scenarios, which run one instance per policy: the computed values, the exact per-opcode latency, fill-before-evict, which entry each policy evicts, and the fact that an operation ignored while busy leaves no entry behind.

// File: rtl/station_pkg.sv
package station_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_MAX = 2'd3
  } op_e;

  typedef enum logic {
    REPL_FIFO = 1'b0,
    REPL_LRU  = 1'b1
  } repl_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/station_alu.sv
module station_alu #(
  parameter int DW = 32
) (
  input  station_pkg::op_e op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    y
);
  import station_pkg::*;

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      default: y = ($signed(a) > $signed(b)) ? a : b;
    endcase
  end
endmodule

// File: rtl/station_cache.sv
module station_cache #(
  parameter int                  DW     = 32,
  parameter int                  DEPTH  = 4,
  parameter station_pkg::repl_e  POLICY = station_pkg::REPL_FIFO,
  localparam int                 KW     = 2 + 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] lk_key,
  input  logic          lk_en,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          wr_en,
  input  logic [KW-1:0] wr_key,
  input  logic [DW-1:0] wr_data
);
  import station_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] OLDEST = AW'(DEPTH - 1);

  logic          valid_q [DEPTH];
  logic [KW-1:0] key_q   [DEPTH];
  logic [DW-1:0] data_q  [DEPTH];
  logic [AW-1:0] age_q   [DEPTH];
  logic [AW-1:0] age_d   [DEPTH];

  logic [AW-1:0] hit_idx;
  logic [AW-1:0] victim_idx;
  logic [AW-1:0] touch_idx;
  logic          touch_en;
  logic          any_free;

  // lookup: at most one entry can hold a given key
  always_comb begin
    lk_hit  = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && key_q[i] == lk_key) begin
        lk_hit  = 1'b1;
        hit_idx = AW'(i);
      end
    end
    lk_data = data_q[hit_idx];
  end

  // victim: lowest empty entry, else the one holding the oldest rank
  always_comb begin
    any_free   = 1'b0;
    victim_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!any_free && age_q[i] == OLDEST) victim_idx = AW'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free   = 1'b1;
        victim_idx = AW'(i);
      end
    end
  end

  // writes and lookups never share a cycle, so one touch port suffices
  always_comb begin
    touch_en  = wr_en || (POLICY == REPL_LRU && lk_en && lk_hit);
    touch_idx = wr_en ? victim_idx : hit_idx;
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (AW'(i) == touch_idx)             age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_here;
    assign wr_here = wr_en && victim_idx == AW'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        age_q[g]   <= AW'(g);
      end else begin
        if (wr_here)  valid_q[g] <= 1'b1;
        if (touch_en) age_q[g]   <= age_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        key_q[g]  <= wr_key;
        data_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/station_ctrl.sv
module station_ctrl #(
  parameter int LAT_ADD = 1,
  parameter int LAT_SUB = 1,
  parameter int LAT_MUL = 4,
  parameter int LAT_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  station_pkg::op_e disp_op,
  input  logic             lk_hit,
  output logic             ready,
  output logic             accept,
  output logic             miss_start,
  output logic             capture
);
  import station_pkg::*;

  localparam int LAT_TOP = (LAT_ADD > LAT_SUB ? LAT_ADD : LAT_SUB) >
                           (LAT_MUL > LAT_MAX ? LAT_MUL : LAT_MAX) ?
                           (LAT_ADD > LAT_SUB ? LAT_ADD : LAT_SUB) :
                           (LAT_MUL > LAT_MAX ? LAT_MUL : LAT_MAX);
  localparam int CW = $clog2(LAT_TOP + 1);

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lat_sel;

  always_comb begin
    unique case (disp_op)
      OP_ADD:  lat_sel = CW'(LAT_ADD);
      OP_SUB:  lat_sel = CW'(LAT_SUB);
      OP_MUL:  lat_sel = CW'(LAT_MUL);
      default: lat_sel = CW'(LAT_MAX);
    endcase
  end

  assign ready      = (st_q == ST_IDLE);
  assign accept     = ready && disp_valid;
  assign miss_start = accept && !lk_hit;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    if (st_q == ST_IDLE) begin
      if (miss_start) begin
        st_d  = ST_WAIT;
        cnt_d = lat_sel - 1'b1;
      end
    end else if (cnt_q == '0) begin
      st_d    = ST_IDLE;
      capture = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/compute_station.sv
module compute_station #(
  parameter int                 DW      = 32,
  parameter int                 DEPTH   = 4,
  parameter station_pkg::repl_e POLICY  = station_pkg::REPL_FIFO,
  parameter int                 LAT_ADD = 1,
  parameter int                 LAT_SUB = 1,
  parameter int                 LAT_MUL = 4,
  parameter int                 LAT_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  output logic          disp_ready,
  input  logic [1:0]    disp_op,
  input  logic [DW-1:0] disp_a,
  input  logic [DW-1:0] disp_b,
  output logic          res_valid,
  output logic [DW-1:0] res_value,
  output logic          res_hit,
  output logic [31:0]   lookup_count,
  output logic [31:0]   hit_count
);
  import station_pkg::*;

  localparam int KW = 2 + 2 * DW;

  op_e           op_in, op_q;
  logic [DW-1:0] a_q, b_q, alu_y, lk_data;
  logic          lk_hit, accept, miss_start, capture;
  logic          hit_take;
  logic [31:0]   lookup_d, hit_d;

  assign op_in    = op_e'(disp_op);
  assign hit_take = accept && lk_hit;

  station_ctrl #(
    .LAT_ADD(LAT_ADD), .LAT_SUB(LAT_SUB), .LAT_MUL(LAT_MUL), .LAT_MAX(LAT_MAX)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_op    (op_in),
    .lk_hit     (lk_hit),
    .ready      (disp_ready),
    .accept     (accept),
    .miss_start (miss_start),
    .capture    (capture)
  );

  station_cache #(.DW(DW), .DEPTH(DEPTH), .POLICY(POLICY)) cache_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_key  ({disp_op, disp_a, disp_b}),
    .lk_en   (accept),
    .lk_hit  (lk_hit),
    .lk_data (lk_data),
    .wr_en   (capture),
    .wr_key  ({op_q, a_q, b_q}),
    .wr_data (alu_y)
  );

  station_alu #(.DW(DW)) alu_i (
    .op (op_q),
    .a  (a_q),
    .b  (b_q),
    .y  (alu_y)
  );

  // operation hold registers, loaded only when a miss starts
  always_ff @(posedge clk) begin
    if (miss_start) begin
      op_q <= op_in;
      a_q  <= disp_a;
      b_q  <= disp_b;
    end
  end

  always_comb begin
    lookup_d = lookup_count + (accept   ? 32'd1 : 32'd0);
    hit_d    = hit_count    + (hit_take ? 32'd1 : 32'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      lookup_count <= '0;
      hit_count    <= '0;
    end else begin
      res_valid <= hit_take || capture;
      if (hit_take || capture) res_hit <= hit_take;
      if (accept)   lookup_count <= lookup_d;
      if (hit_take) hit_count    <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit_take)     res_value <= lk_data;
    else if (capture) res_value <= alu_y;
  end
endmodule

// File: rtl/station_checker.sv
module station_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        disp_valid,
  input logic        disp_ready,
  input logic        res_valid,
  input logic        res_hit,
  input logic [31:0] lookup_count,
  input logic [31:0] hit_count
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> (res_valid && res_hit) || !disp_ready);

  p_miss_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !$past(disp_ready));

  p_hit_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> $past(disp_valid && disp_ready));

  p_lookup_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> lookup_count == $past(lookup_count) + 32'd1);

  p_hit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> hit_count == $past(hit_count) + 32'd1);

  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && disp_ready) |=> $stable(lookup_count) && $stable(hit_count));

  always_comb begin
    if (rst_n) p_hit_bound_r6: assert (hit_count <= lookup_count);
  end
endmodule

bind compute_station station_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_valid   (disp_valid),
  .disp_ready   (disp_ready),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .lookup_count (lookup_count),
  .hit_count    (hit_count)
);

// File: tb/compute_station_tb_top.sv
module compute_station_tb_top;
  import station_pkg::*;

  localparam int DW = 32;
  localparam int L_ADD = 1, L_SUB = 1, L_MUL = 4, L_MAX = 2;

  logic clk, rst_n;
  logic          dv   [2];
  logic [1:0]    dop  [2];
  logic [DW-1:0] da   [2];
  logic [DW-1:0] db   [2];
  logic          rdy  [2];
  logic          rv   [2];
  logic          rh   [2];
  logic [DW-1:0] rval [2];
  logic [31:0]   lc   [2];
  logic [31:0]   hc   [2];

  int total = 0, bad = 0;
  int exp_lk [2];
  int exp_ht [2];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  compute_station #(.DW(DW), .DEPTH(4), .POLICY(REPL_FIFO),
    .LAT_ADD(L_ADD), .LAT_SUB(L_SUB), .LAT_MUL(L_MUL), .LAT_MAX(L_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv[0]), .disp_ready(rdy[0]),
    .disp_op(dop[0]), .disp_a(da[0]), .disp_b(db[0]), .res_valid(rv[0]),
    .res_value(rval[0]), .res_hit(rh[0]), .lookup_count(lc[0]), .hit_count(hc[0]));

  compute_station #(.DW(DW), .DEPTH(4), .POLICY(REPL_LRU),
    .LAT_ADD(L_ADD), .LAT_SUB(L_SUB), .LAT_MUL(L_MUL), .LAT_MAX(L_MAX)) dut_lru_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv[1]), .disp_ready(rdy[1]),
    .disp_op(dop[1]), .disp_a(da[1]), .disp_b(db[1]), .res_valid(rv[1]),
    .res_value(rval[1]), .res_hit(rh[1]), .lookup_count(lc[1]), .hit_count(hc[1]));

  function automatic logic [DW-1:0] model(input logic [1:0] op, input logic [DW-1:0] a, b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a * b;
      default: return ($signed(a) > $signed(b)) ? a : b;
    endcase
  endfunction

  function automatic int lat_of(input logic [1:0] op);
    case (op)
      2'd0:    return L_ADD;
      2'd1:    return L_SUB;
      2'd2:    return L_MUL;
      default: return L_MAX;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // issue one operation on station s and check timing, value, hit flag, counters
  task automatic issue(input int s, input logic [1:0] op, input logic [DW-1:0] a, b,
                       input bit exp_hit, input string tag);
    int n;
    logic rdy_busy;
    @(negedge clk);
    chk("R1", "ready before issue", {31'd0, rdy[s]}, 32'd1);
    dv[s] = 1'b1; dop[s] = op; da[s] = a; db[s] = b;
    @(negedge clk);
    dv[s] = 1'b0;
    n = 1;
    rdy_busy = rdy[s];
    while (!rv[s] && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!exp_hit) chk("R1", "ready during countdown", {31'd0, rdy_busy}, 32'd0);
    chk(exp_hit ? "R4" : "R3", "result cycle", n, exp_hit ? 1 : lat_of(op) + 1);
    chk("R2", "result value", rval[s], model(op, a, b));
    chk(tag, "hit flag", {31'd0, rh[s]}, {31'd0, exp_hit});
    exp_lk[s]++;
    if (exp_hit) exp_ht[s]++;
    chk("R6", "lookup count", lc[s], exp_lk[s]);
    chk("R6", "hit count", hc[s], exp_ht[s]);
    @(negedge clk);
    chk("R3", "single-cycle result", {31'd0, rv[s]}, 32'd0);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk("R1", "reset ready", {31'd0, rdy[s]}, 32'd1);
      chk("R1", "reset res_valid", {31'd0, rv[s]}, 32'd0);
      chk("R1", "reset lookups", lc[s], 32'd0);
      chk("R1", "reset hits", hc[s], 32'd0);
    end
  endtask

  task automatic t_fifo();
    issue(0, 2'd0, 32'd5, 32'd7, 1'b0, "R7");
    issue(0, 2'd1, 32'd5, 32'd7, 1'b0, "R7");
    issue(0, 2'd2, 32'd5, 32'd7, 1'b0, "R7");
    issue(0, 2'd3, 32'hFFFF_FFFD, 32'd2, 1'b0, "R7");
    issue(0, 2'd3, 32'hFFFF_FFFD, 32'd2, 1'b1, "R7");
    issue(0, 2'd1, 32'd5, 32'd7, 1'b1, "R7");
    issue(0, 2'd0, 32'd5, 32'd7, 1'b1, "R7");
    issue(0, 2'd2, 32'd5, 32'd7, 1'b1, "R7");
    issue(0, 2'd0, 32'd7, 32'd5, 1'b0, "R5");   // swapped operands, evicts ADD(5,7)
    issue(0, 2'd0, 32'd5, 32'd7, 1'b0, "R8");   // oldest write gone despite hit
    issue(0, 2'd2, 32'd5, 32'd7, 1'b1, "R8");
    issue(0, 2'd1, 32'd5, 32'd7, 1'b0, "R8");
  endtask

  task automatic t_lru();
    issue(1, 2'd0, 32'd5, 32'd7, 1'b0, "R7");
    issue(1, 2'd1, 32'd5, 32'd7, 1'b0, "R7");
    issue(1, 2'd2, 32'd5, 32'd7, 1'b0, "R7");
    issue(1, 2'd3, 32'hFFFF_FFFD, 32'd2, 1'b0, "R7");
    issue(1, 2'd0, 32'd5, 32'd7, 1'b1, "R9");   // refresh ADD
    issue(1, 2'd0, 32'd6, 32'd7, 1'b0, "R5");   // evicts SUB
    issue(1, 2'd0, 32'd5, 32'd7, 1'b1, "R9");
    issue(1, 2'd1, 32'd5, 32'd7, 1'b0, "R9");   // evicts MUL
    issue(1, 2'd3, 32'hFFFF_FFFD, 32'd2, 1'b1, "R9");
    issue(1, 2'd2, 32'd5, 32'd7, 1'b0, "R9");
  endtask

  task automatic t_ignored();
    int n;
    @(negedge clk);
    dv[0] = 1'b1; dop[0] = 2'd2; da[0] = 32'd9; db[0] = 32'd9;
    @(negedge clk);
    dop[0] = 2'd0; da[0] = 32'd1; db[0] = 32'd1;   // presented while busy
    n = 1;
    while (!rv[0] && n < 40) begin
      @(negedge clk);
      n++;
    end
    dv[0] = 1'b0;
    exp_lk[0]++;
    chk("R10", "busy result value", rval[0], 32'd81);
    chk("R10", "busy lookup count", lc[0], exp_lk[0]);
    issue(0, 2'd0, 32'd1, 32'd1, 1'b0, "R10");      // was not stored
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int s = 0; s < 2; s++) begin
      dv[s] = 1'b0; dop[s] = '0; da[s] = '0; db[s] = '0;
      exp_lk[s] = 0; exp_ht[s] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fifo();
    t_lru();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule